// File: doc/BRIEF.md
# Banked Fractional-N Feedback Divider Sequencer

This block produces the division modulus that the feedback divider of a fractional-N synthesizer applies on each reference cycle. The modulus is the integer part of the ratio plus a small signed correction. A third-order cascade of first-order delta-sigma stages (MASH 1-1-1) produces the correction. Over a long run the corrections average to the fractional part plus half of its least significant bit. The fraction is therefore never exactly zero, and the modulator's quantisation noise is pushed to high offset frequencies.

Four configuration banks hold divider settings. Each bank has a 2-bit pre-divider code, a 7-bit integer part, an 18-bit fraction and a 7-bit post-divider code. A 2-bit select input picks the active bank. A change of select takes effect on the next clock edge, and that switch clears the modulator state. A simple write port and a same-cycle read port give access to every field of every bank. Reset reloads fixed default settings.

The divider is stepped once per asserted feedback enable. The analog loop, the oscillator, the clock dividers themselves and any serial protocol engine are outside this block.

Top module: `fracn_bank_seq`

## Requirements
- R1: Reset loads bank i with pre = i, integer = 24 + 8*i, fraction = 4096*(i+1) and post = 4*(i+1). After reset the outputs show the bank chosen by `sel`.
- R2: Field code 0 is the pre-divider (bits 1:0), 1 the integer part (6:0), 2 the fraction (17:0) and 3 the post-divider (6:0). A write with `wr_en` high stores the low bits of `wr_data` at the clock edge. `rd_data` returns the addressed field zero-extended in the same cycle.
- R3: A `sel` value k selects bank k. After the edge on which a new value of `sel` is first sampled, `pre_div`, `post_div` and `fb_mod` hold that bank's pre-divider, post-divider and integer part.
- R4: `fb_mod` is a 9-bit two's complement value equal to the active integer part plus a correction in the range -3 to +4.
- R5: While `sel` is unchanged, `pre_div` and `post_div` hold their values even when the selected bank is written. Such writes take effect at the next bank switch.
- R6: While `fb_en` is low and `sel` is unchanged, `fb_mod` holds its value.
- R7: Over N enabled steps after a switch, the corrections sum to between floor(N*(2F+1)/2^19) - 1 and that value + 2, where F is the fraction.
- R8: A bank switch clears the modulator. The same bank therefore yields the same correction sequence after every switch into it, and the first enabled step after a switch yields the integer part exactly.
- R9: With a fraction of zero, the modulus still departs from the integer part within 300 enabled steps.
- R10: Writes to banks other than the selected one leave the running modulus sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads default banks |
| sel | input | 2 | Active bank select |
| fb_en | input | 1 | Advance the modulator by one feedback step |
| wr_en | input | 1 | Register write strobe |
| wr_bank | input | 2 | Bank index for a write |
| wr_field | input | 2 | Field code for a write |
| wr_data | input | 32 | Write data, low bits used |
| rd_bank | input | 2 | Bank index for a read |
| rd_field | input | 2 | Field code for a read |
| rd_data | output | 32 | Addressed field, zero-extended, combinational |
| fb_mod | output | 9 | Instantaneous feedback modulus, two's complement |
| pre_div | output | 2 | Active pre-divider code |
| post_div | output | 7 | Active post-divider code |

## Verification
The bench targets the half-LSB offset with a zero fraction. A design that dropped the offset would emit the bare integer part forever. Long-run sums are checked against the exact rational average for two fractions, which exposes a wrong carry weighting or a missing difference term in the cancellation network. Replaying the same bank after switching away and back detects a modulator that is not cleared on a switch, and concurrent writes to other banks in that replay detect a sequencer reading live bank storage. Writes to the selected bank followed by a switch detect a design that applies those writes at once or never.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  parameter int unsigned SEL_W  = 2;
  parameter int unsigned NBANK  = 1 << SEL_W;
  parameter int unsigned P_W    = 2;
  parameter int unsigned MI_W   = 7;
  parameter int unsigned MF_W   = 18;
  parameter int unsigned N_W    = 7;
  parameter int unsigned DW     = 32;
  parameter int unsigned CORR_W = 4;
  localparam int unsigned ACC_W = MF_W + 1;
  localparam int unsigned MOD_W = MI_W + 2;

  typedef enum logic [1:0] {
    FLD_PRE  = 2'd0,
    FLD_INT  = 2'd1,
    FLD_FRAC = 2'd2,
    FLD_POST = 2'd3
  } fld_e;

  typedef struct packed {
    logic [P_W-1:0]  pre;
    logic [MI_W-1:0] mint;
    logic [MF_W-1:0] frac;
    logic [N_W-1:0]  post;
  } bank_t;

  function automatic bank_t bank_default(input int unsigned idx);
    bank_t b;
    b.pre  = P_W'(idx);
    b.mint = MI_W'(24 + 8 * idx);
    b.frac = MF_W'(4096 * (idx + 1));
    b.post = N_W'(4 * (idx + 1));
    return b;
  endfunction
endpackage

// File: rtl/fracn_bank_regs.sv
module fracn_bank_regs
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_bank,
  input  logic [1:0]       wr_field,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_bank,
  input  logic [1:0]       rd_field,
  output logic [DW-1:0]    rd_data,
  input  logic [SEL_W-1:0] sel,
  output bank_t            sel_bank
);
  bank_t banks [NBANK];
  bank_t rb;

  always_ff @(posedge clk) begin
    for (int i = 0; i < NBANK; i++) begin
      if (rst) begin
        banks[i] <= bank_default(i);
      end else if (wr_en && wr_bank == SEL_W'(i)) begin
        case (fld_e'(wr_field))
          FLD_PRE:  banks[i].pre  <= wr_data[P_W-1:0];
          FLD_INT:  banks[i].mint <= wr_data[MI_W-1:0];
          FLD_FRAC: banks[i].frac <= wr_data[MF_W-1:0];
          default:  banks[i].post <= wr_data[N_W-1:0];
        endcase
      end
    end
  end

  assign rb       = banks[rd_bank];
  assign sel_bank = banks[sel];

  always_comb begin
    rd_data = '0;
    case (fld_e'(rd_field))
      FLD_PRE:  rd_data[P_W-1:0]  = rb.pre;
      FLD_INT:  rd_data[MI_W-1:0] = rb.mint;
      FLD_FRAC: rd_data[MF_W-1:0] = rb.frac;
      default:  rd_data[N_W-1:0]  = rb.post;
    endcase
  end
endmodule

// File: rtl/fracn_mash111.sv
module fracn_mash111
  import fracn_pkg::*;
#(
  parameter int unsigned AW  = ACC_W,
  parameter int unsigned CW  = CORR_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic [AW-1:0]        x,
  output logic signed [CW-1:0] corr,
  output logic                 acc_clear
);
  localparam int unsigned NST = 3;

  logic [NST-1:0][AW-1:0] acc_q;
  logic [NST-1:0][AW-1:0] sum;
  logic [NST-1:0]         cy;
  logic                   c2_d, c3_d, c3_dd;

  for (genvar k = 0; k < NST; k++) begin : g_stage
    logic [AW-1:0] din;
    if (k == 0) begin : g_first
      assign din = x;
    end else begin : g_next
      assign din = sum[k-1];
    end
    assign {cy[k], sum[k]} = {1'b0, acc_q[k]} + {1'b0, din};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      c2_d  <= 1'b0;
      c3_d  <= 1'b0;
      c3_dd <= 1'b0;
    end else if (en) begin
      acc_q <= sum;
      c2_d  <= cy[1];
      c3_d  <= cy[2];
      c3_dd <= c3_d;
    end
  end

  // first carry, plus first difference of second, plus second difference of third
  assign corr = CW'(cy[0]) + CW'(cy[1]) - CW'(c2_d)
              + CW'(cy[2]) - CW'({c3_d, 1'b0}) + CW'(c3_dd);

  assign acc_clear = (acc_q == '0);
endmodule

// File: rtl/fracn_bank_seq.sv
module fracn_bank_seq
  import fracn_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             fb_en,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_bank,
  input  logic [1:0]       wr_field,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_bank,
  input  logic [1:0]       rd_field,
  output logic [DW-1:0]    rd_data,
  output logic [MOD_W-1:0] fb_mod,
  output logic [P_W-1:0]   pre_div,
  output logic [N_W-1:0]   post_div
);
  bank_t                     sel_bank;
  bank_t                     act_q;
  logic [SEL_W-1:0]          sel_q;
  logic                      swap;
  logic signed [CORR_W-1:0]  corr;
  logic                      acc_clear;
  bank_t                     rst_bank;

  fracn_bank_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_bank  (wr_bank),
    .wr_field (wr_field),
    .wr_data  (wr_data),
    .rd_bank  (rd_bank),
    .rd_field (rd_field),
    .rd_data  (rd_data),
    .sel      (sel),
    .sel_bank (sel_bank)
  );

  assign swap     = (sel != sel_q);
  assign rst_bank = bank_default(32'(sel));

  fracn_mash111 u_mash (
    .clk       (clk),
    .rst       (rst),
    .clr       (swap),
    .en        (fb_en),
    .x         ({act_q.frac, 1'b1}),
    .corr      (corr),
    .acc_clear (acc_clear)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= sel;
      act_q    <= rst_bank;
      pre_div  <= rst_bank.pre;
      post_div <= rst_bank.post;
      fb_mod   <= MOD_W'(rst_bank.mint);
    end else if (swap) begin
      sel_q    <= sel;
      act_q    <= sel_bank;
      pre_div  <= sel_bank.pre;
      post_div <= sel_bank.post;
      fb_mod   <= MOD_W'(sel_bank.mint);
    end else if (fb_en) begin
      fb_mod   <= MOD_W'(act_q.mint) + {{(MOD_W-CORR_W){corr[CORR_W-1]}}, corr};
    end
  end
endmodule

// File: rtl/fracn_bank_seq_chk.sv
module fracn_bank_seq_chk
  import fracn_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic [SEL_W-1:0] sel,
  input logic             fb_en,
  input logic [1:0]       rd_field,
  input logic [DW-1:0]    rd_data,
  input logic [MOD_W-1:0] fb_mod,
  input logic [P_W-1:0]   pre_div,
  input logic [N_W-1:0]   post_div,
  input logic [MI_W-1:0]  act_mint,
  input logic             acc_clear
);
  logic arm1, arm2;
  logic signed [MOD_W:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm1 <= 1'b0;
      arm2 <= 1'b0;
    end else begin
      arm1 <= 1'b1;
      arm2 <= arm1;
    end
  end

  assign diff = $signed({fb_mod[MOD_W-1], fb_mod}) - $signed((MOD_W+1)'(act_mint));

  // R5
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arm1 && arm2 && $past(sel) == $past(sel, 2)) |-> ($stable(pre_div) && $stable(post_div)));

  // R6
  mod_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arm1 && arm2 && $past(sel) == $past(sel, 2) && !$past(fb_en)) |-> $stable(fb_mod));

  // R4
  corr_range_chk: assert property (@(posedge clk) disable iff (rst)
    arm1 |-> (diff >= -3 && diff <= 4));

  // R8
  swap_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (arm1 && sel != $past(sel)) |=> acc_clear);

  // R2
  rd_pre_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_field == 2'd0) |-> (rd_data[DW-1:P_W] == '0));

  // R2
  rd_frac_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_field == 2'd2) |-> (rd_data[DW-1:MF_W] == '0));
endmodule

bind fracn_bank_seq fracn_bank_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .sel       (sel),
  .fb_en     (fb_en),
  .rd_field  (rd_field),
  .rd_data   (rd_data),
  .fb_mod    (fb_mod),
  .pre_div   (pre_div),
  .post_div  (post_div),
  .act_mint  (act_q.mint),
  .acc_clear (acc_clear)
);

// File: tb/fracn_bank_seq_test.sv
module fracn_bank_seq_test;
  import fracn_pkg::*;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SEL_W-1:0] sel = '0;
  logic             fb_en = 1'b0;
  logic             wr_en = 1'b0;
  logic [SEL_W-1:0] wr_bank = '0;
  logic [1:0]       wr_field = '0;
  logic [DW-1:0]    wr_data = '0;
  logic [SEL_W-1:0] rd_bank = '0;
  logic [1:0]       rd_field = '0;
  logic [DW-1:0]    rd_data;
  logic [MOD_W-1:0] fb_mod;
  logic [P_W-1:0]   pre_div;
  logic [N_W-1:0]   post_div;

  fracn_bank_seq uut (
    .clk(clk), .rst(rst), .sel(sel), .fb_en(fb_en),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_field(wr_field), .wr_data(wr_data),
    .rd_bank(rd_bank), .rd_field(rd_field), .rd_data(rd_data),
    .fb_mod(fb_mod), .pre_div(pre_div), .post_div(post_div)
  );

  always #10 clk = ~clk;

  typedef struct {
    int     kind;
    string  req;
    longint exp;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  int    rec1[200];
  int    rec2[200];

  function automatic void tally(string req, bit ok, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endfunction

  function automatic longint peek(int kind);
    case (kind)
      0:       return longint'(rd_data);
      1:       return longint'(pre_div);
      2:       return longint'(post_div);
      default: return longint'($signed(fb_mod));
    endcase
  endfunction

  // monitor: compares every queued expectation at the falling edge
  initial begin : monitor
    item_t  it;
    longint a;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        it = q.pop_front();
        a  = peek(it.kind);
        tally(it.req, a == it.exp, a, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic push(int kind, longint exp, string req);
    item_t it;
    it.kind = kind;
    it.req  = req;
    it.exp  = exp;
    q.push_back(it);
  endtask

  task automatic wr(int b, int f, logic [DW-1:0] d);
    wr_en    = 1'b1;
    wr_bank  = SEL_W'(b);
    wr_field = 2'(f);
    wr_data  = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(int b, int f, longint exp, string req);
    rd_bank  = SEL_W'(b);
    rd_field = 2'(f);
    push(0, exp, req);
    step();
  endtask

  task automatic swap_to(int s);
    fb_en = 1'b0;
    sel   = SEL_W'(s);
    step();
  endtask

  task automatic outs_chk(longint p, longint n, longint m, string req);
    push(1, p, req);
    push(2, n, req);
    push(3, m, req);
    step();
  endtask

  // runs n enabled steps, checks per-step range and the long-run sum
  task automatic run_avg(int n, int mint, int frac, string req);
    longint sum = 0;
    longint lo;
    int     bad = 0;
    int     d;
    fb_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      d = int'($signed(fb_mod)) - mint;
      if (d < -3 || d > 4) bad++;
      sum += d;
    end
    fb_en = 1'b0;
    tally("R4 range", bad == 0, bad, 0);
    lo = (longint'(n) * (2 * longint'(frac) + 1)) >>> 19;
    tally(req, sum >= lo - 1 && sum <= lo + 2, sum, lo);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    int v;
    int nz;
    int d;
    int mism;
    repeat (3) step();
    rst = 1'b0;
    // R1 reset state of outputs with sel = 0
    outs_chk(0, 4, 24, "R1 reset outputs");
    // R1 R2 default contents of all banks
    for (int b = 0; b < 4; b++) begin
      rd_chk(b, 0, b, "R1 default pre");
      rd_chk(b, 1, 24 + 8 * b, "R1 default int");
      rd_chk(b, 2, 4096 * (b + 1), "R1 default frac");
      rd_chk(b, 3, 4 * (b + 1), "R2 default post");
    end
    // R3 select mapping
    swap_to(2);
    outs_chk(2, 12, 40, "R3 select bank 2");
    swap_to(3);
    outs_chk(3, 16, 48, "R3 select bank 3");
    // R2 write and read back
    wr(1, 0, 32'd3);
    wr(1, 1, 32'd50);
    wr(1, 2, 32'h0002_0000);
    wr(1, 3, 32'd9);
    rd_chk(1, 0, 3, "R2 readback pre");
    rd_chk(1, 1, 50, "R2 readback int");
    rd_chk(1, 2, 32'h0002_0000, "R2 readback frac");
    rd_chk(1, 3, 9, "R2 readback post");
    wr(2, 2, 32'hFFFF_FFFF);
    rd_chk(2, 2, 32'h0003_FFFF, "R2 frac truncation");
    wr(2, 0, 32'hFFFF_FFFD);
    rd_chk(2, 0, 1, "R2 pre truncation");
    wr(2, 2, 32'h0000_ABCD);
    wr(2, 1, 32'd60);
    // R5 write to selected bank is deferred
    wr(3, 3, 32'd99);
    wr(3, 0, 32'd1);
    outs_chk(3, 16, 48, "R5 selected bank write deferred");
    rd_chk(3, 3, 99, "R5 storage updated");
    swap_to(0);
    outs_chk(0, 4, 24, "R3 select bank 0");
    swap_to(3);
    outs_chk(1, 99, 48, "R5 applied at next switch");
    // R6 hold while enable is low
    swap_to(1);
    outs_chk(3, 9, 50, "R3 select bank 1");
    fb_en = 1'b1;
    repeat (20) step();
    fb_en = 1'b0;
    step();
    v = int'($signed(fb_mod));
    for (int i = 0; i < 10; i++) begin
      step();
      tally("R6 hold", int'($signed(fb_mod)) == v, int'($signed(fb_mod)), v);
    end
    // R7 long-run averages for two fractions
    swap_to(0);
    swap_to(1);
    run_avg(4096, 50, 32'h2_0000, "R7 average half");
    swap_to(2);
    run_avg(4096, 60, 32'h0_ABCD, "R7 average odd");
    // R8 R10 repeatability after switch, with writes to other banks
    swap_to(0);
    swap_to(1);
    push(3, 50, "R8 first value after switch");
    step();
    fb_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      step();
      rec1[i] = int'($signed(fb_mod));
    end
    swap_to(0);
    swap_to(1);
    fb_en = 1'b1;
    for (int i = 0; i < 200; i++) begin
      wr_en    = 1'b1;
      wr_bank  = (i % 2 == 0) ? SEL_W'(0) : SEL_W'(2);
      wr_field = 2'(i % 4);
      wr_data  = DW'(i + 5);
      step();
      rec2[i] = int'($signed(fb_mod));
    end
    wr_en = 1'b0;
    fb_en = 1'b0;
    tally("R8 first enabled step", rec1[0] == 50, rec1[0], 50);
    mism = 0;
    for (int i = 0; i < 200; i++) if (rec1[i] != rec2[i]) mism++;
    tally("R10 sequence undisturbed", mism == 0, mism, 0);
    // R9 half-LSB offset with zero fraction
    wr(0, 1, 32'd30);
    wr(0, 2, 32'd0);
    swap_to(0);
    push(3, 30, "R9 switch to zero fraction");
    step();
    nz = 0;
    fb_en = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step();
      d = int'($signed(fb_mod)) - 30;
      if (d != 0) nz++;
    end
    fb_en = 1'b0;
    tally("R9 nonzero corrections", nz > 0, nz, 1);
    step();
    step();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule